// File: doc/BRIEF.md
# Clock Deskew Trim Controller

This block is the digital half of one region's clock deskew buffer. It watches a lead/lag decision that compares the region's returned clock with a shared reference, and it steps a 20-bit thermometer word that sets an external delay line. The word is moved one position at a time. A move happens only after the decision has been sampled several times at a slow, fixed rate and every one of those samples agrees. This keeps jitter from making the loop hunt back and forth.

A small register port sits beside the loop. Through it the trim word can be captured for readback or replaced with a chosen value. A manual-mode input stops all automatic correction, so that a value loaded by hand stays in place and skew between regions can be set up on purpose. If the word is already at an end of its range and a correction asks for a further move that way, the word stays where it is and a one-cycle saturation pulse is raised.

Top module: `skew_trim_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `trim_code` holds the midpoint word 20'hFFC00 (ones in bits 19..10, zeros in bits 9..0), `trim_sat` is 0 and `cfg_rdata` is 0.
- R2: The lead input passes through a two-flop synchronizer. It is sampled once every 16 clock cycles, and the first sample is taken at the 16th rising edge after reset is released. A sample sees the input as it stood before the rising edge two edges earlier.
- R3: A correction is issued only when the four most recent samples are all equal. It changes `trim_code` at the edge after the fourth sample. If the samples in that window disagree, `trim_code` stays unchanged.
- R4: Issuing a correction clears the sample history. Under a steady input, therefore, successive corrections are 64 cycles apart.
- R5: A sample of 1 (feedback leads) slows the line: the word shifts toward bit 19 and a 0 enters at bit 0, so one fewer bit is set. A sample of 0 speeds the line up: the word shifts toward bit 0 and a 1 enters at bit 19, so one more bit is set.
- R6: A speed-up correction on an all-ones word, or a slow-down correction on an all-zeros word, leaves the word unchanged. In that case `trim_sat` is high for exactly one cycle, starting at the edge where the word would otherwise have changed.
- R7: When `cfg_wr` is high at an edge, `cfg_wdata` is loaded into `trim_code`. When `cfg_rd` is high at an edge, the current `trim_code` is captured into `cfg_rdata`.
- R8: While `cfg_manual` is high, no automatic correction is issued and the sample history is held empty, but writes still take effect. Once manual mode is released, the next correction needs four fresh agreeing samples.
- R9: A write that coincides with a correction wins. The correction is discarded, and the next correction needs four fresh samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with the clock |
| fb_leads | input | 1 | Lead/lag decision, 1 = feedback clock leads (more delay wanted) |
| cfg_manual | input | 1 | High blocks automatic correction |
| cfg_wr | input | 1 | Write strobe for the trim word |
| cfg_wdata | input | 20 | Value loaded by a write |
| cfg_rd | input | 1 | Read strobe, captures the trim word |
| cfg_rdata | output | 20 | Last captured trim word |
| trim_code | output | 20 | Thermometer word driving the delay line |
| trim_sat | output | 1 | One-cycle pulse when a correction hits an end of range |

## Verification
The embedded properties take for granted that reset is released on a clock edge boundary and that the lead input is the only asynchronous signal. The register strobes and the manual bit are assumed to be synchronous to the reference clock. The step-size property also assumes that the word holds a thermometer pattern whenever a correction arrives, which a write does not guarantee. Because of this, the bench only ever writes all-ones, all-zeros or values whose shifted result it predicts directly, and it changes every strobe and data input on the falling edge.

// File: rtl/skew_trim_pkg.sv
package skew_trim_pkg;

  // Direction of one trim correction leaving the vote filter.
  typedef enum logic [1:0] {
    STEP_NONE   = 2'b00,
    STEP_FASTER = 2'b01,
    STEP_SLOWER = 2'b10
  } step_e;

endpackage

// File: rtl/skew_trim_tick.sv
module skew_trim_tick #(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  // R2: sample strobes never come back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/skew_trim_vote.sv
module skew_trim_vote
  import skew_trim_pkg::*;
#(
  parameter int unsigned VOTE_LEN    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lead_i,
  input  logic  tick_i,
  input  logic  hold_i,
  output step_e corr_o
);

  localparam int unsigned FW = $clog2(VOTE_LEN + 1);
  localparam logic [FW-1:0] FULL = FW'(VOTE_LEN);

  // synchronizer chain
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   lead_s;

  assign sync_d = {sync_q[SYNC_STAGES-2:0], lead_i};
  assign lead_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  // sample history and vote
  logic [VOTE_LEN-1:0] hist_q, hist_d, window;
  logic [FW-1:0]       fill_q, fill_d, fill_inc;
  logic                hist_en;
  logic                unanimous;
  step_e               corr_q, corr_d;

  assign window    = {hist_q[VOTE_LEN-2:0], lead_s};
  assign fill_inc  = (fill_q == FULL) ? fill_q : fill_q + 1'b1;
  assign unanimous = (window == '0) || (&window);

  always_comb begin
    hist_en = 1'b0;
    hist_d  = hist_q;
    fill_d  = fill_q;
    corr_d  = STEP_NONE;
    if (hold_i) begin
      hist_en = 1'b1;
      hist_d  = '0;
      fill_d  = '0;
    end else if (tick_i) begin
      hist_en = 1'b1;
      if ((fill_inc == FULL) && unanimous) begin
        corr_d = window[0] ? STEP_SLOWER : STEP_FASTER;
        hist_d = '0;
        fill_d = '0;
      end else begin
        hist_d = window;
        fill_d = fill_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (hist_en) begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) corr_q <= STEP_NONE;
    else        corr_q <= corr_d;
  end

  assign corr_o = corr_q;

  // R3: the history count never exceeds the vote length
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL);
  // R8: manual mode blocks every correction
  p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (corr_q == STEP_NONE));
  // R2: a correction only follows a sample strobe
  p_corr_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_q != STEP_NONE) |-> $past(tick_i));
  // R4: corrections are never issued on consecutive cycles
  p_corr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_q != STEP_NONE) |=> (corr_q == STEP_NONE));

endmodule

// File: rtl/skew_trim_therm.sv
module skew_trim_therm
  import skew_trim_pkg::*;
#(
  parameter int unsigned CODE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             corr_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] rdata_o,
  output logic              sat_o
);

  localparam int unsigned       MID_ONES = CODE_W / 2;
  localparam logic [CODE_W-1:0] ALL_ONES = '1;
  localparam logic [CODE_W-1:0] MID_CODE = ~(ALL_ONES >> MID_ONES);

  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] rdata_q;
  logic              code_en;
  logic              sat_q, sat_d;
  logic              at_top, at_bot;

  assign at_top = &code_q;
  assign at_bot = ~|code_q;

  always_comb begin
    code_en = 1'b0;
    code_d  = code_q;
    sat_d   = 1'b0;
    if (wr_i) begin
      code_en = 1'b1;
      code_d  = wdata_i;
    end else begin
      case (corr_i)
        STEP_SLOWER: begin
          if (at_bot) sat_d = 1'b1;
          else begin
            code_en = 1'b1;
            code_d  = {code_q[CODE_W-2:0], 1'b0};
          end
        end
        STEP_FASTER: begin
          if (at_top) sat_d = 1'b1;
          else begin
            code_en = 1'b1;
            code_d  = {1'b1, code_q[CODE_W-1:1]};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= MID_CODE;
    else if (code_en) code_q <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sat_q <= 1'b0;
    else        sat_q <= sat_d;
  end

  assign code_o  = code_q;
  assign rdata_o = rdata_q;
  assign sat_o   = sat_q;

  // R6: saturation is only reported with the word at an end of range
  p_sat_rail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q |-> (at_top || at_bot));
  // R7: with no write and no correction the word holds
  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && corr_i == STEP_NONE) |=> $stable(code_q));
  // R9: a write lands regardless of a coincident correction
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (code_q == $past(wdata_i)));
  // R5: an automatic step moves the set-bit count by at most one
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && corr_i != STEP_NONE) |=>
      (($countones(code_q) <= $countones($past(code_q)) + 1) &&
       ($countones(code_q) + 1 >= $countones($past(code_q)))));

endmodule

// File: rtl/skew_trim_ctrl.sv
module skew_trim_ctrl
  import skew_trim_pkg::*;
#(
  parameter int unsigned CODE_W      = 20,
  parameter int unsigned PERIOD      = 16,
  parameter int unsigned VOTE_LEN    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              fb_leads,
  input  logic              cfg_manual,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_wdata,
  input  logic              cfg_rd,
  output logic [CODE_W-1:0] cfg_rdata,
  output logic [CODE_W-1:0] trim_code,
  output logic              trim_sat
);

  logic  tick;
  step_e corr;

  skew_trim_tick #(.PERIOD(PERIOD)) u_tick (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  skew_trim_vote #(.VOTE_LEN(VOTE_LEN), .SYNC_STAGES(SYNC_STAGES)) u_vote (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .lead_i (fb_leads),
    .tick_i (tick),
    .hold_i (cfg_manual),
    .corr_o (corr)
  );

  skew_trim_therm #(.CODE_W(CODE_W)) u_therm (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .corr_i  (corr),
    .wr_i    (cfg_wr),
    .wdata_i (cfg_wdata),
    .rd_i    (cfg_rd),
    .code_o  (trim_code),
    .rdata_o (cfg_rdata),
    .sat_o   (trim_sat)
  );

  // R8: nothing but a write moves the word while manual mode is held
  p_manual_freeze_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cfg_manual && $past(cfg_manual) && !cfg_wr) |=> $stable(trim_code));

endmodule

// File: tb/tb_skew_trim_ctrl.sv
module tb_skew_trim_ctrl;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [19:0] MID = 20'hFFC00;

  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        fb_leads;
  logic        cfg_manual;
  logic        cfg_wr;
  logic [19:0] cfg_wdata;
  logic        cfg_rd;
  logic [19:0] cfg_rdata;
  logic [19:0] trim_code;
  logic        trim_sat;

  int n_chk  = 0;
  int n_fail = 0;
  int cur    = 0;
  int sat_cnt = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  always @(posedge clk_ref) if (rst_n && trim_sat) sat_cnt <= sat_cnt + 1;

  skew_trim_ctrl dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .fb_leads(fb_leads),
    .cfg_manual(cfg_manual), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata), .trim_code(trim_code),
    .trim_sat(trim_sat)
  );

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lead, input logic manual);
    rst_n = 1'b0; fb_leads = lead; cfg_manual = manual;
    cfg_wr = 1'b0; cfg_wdata = '0; cfg_rd = 1'b0;
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
    cur = 0;
  endtask

  // advance to the falling edge that follows rising edge e
  task automatic run_to(input int e);
    repeat (e - cur) @(posedge clk_ref);
    cur = e;
    @(negedge clk_ref);
  endtask

  task automatic t_reset;
    do_reset(1'b1, 1'b0);
    check("R1 reset word", trim_code, MID);
    check("R1 reset sat", {19'b0, trim_sat}, 20'h0);
    check("R1 reset rdata", cfg_rdata, 20'h0);
    run_to(15);
    check("R1 word before first sample", trim_code, MID);
  endtask

  task automatic t_slow;
    do_reset(1'b1, 1'b0);
    run_to(64);
    check("R3 no change before fourth sample applies", trim_code, MID);
    run_to(65);
    check("R5 slow-down step", trim_code, 20'hFF800);
    run_to(128);
    check("R4 no step before four fresh samples", trim_code, 20'hFF800);
    run_to(129);
    check("R4 second step 64 cycles later", trim_code, 20'hFF000);
  endtask

  task automatic t_fast;
    do_reset(1'b0, 1'b0);
    run_to(65);
    check("R5 speed-up step", trim_code, 20'hFFE00);
  endtask

  task automatic t_sync_delay;
    do_reset(1'b0, 1'b0);
    run_to(14);
    fb_leads = 1'b1;
    run_to(65);
    check("R2 late input misses first sample", trim_code, MID);
    run_to(81);
    check("R2 step after fifth sample", trim_code, 20'hFF800);
  endtask

  task automatic t_jitter;
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 12; k++) begin
      run_to(16 * k + 8);
      fb_leads = ~fb_leads;
    end
    run_to(200);
    check("R3 alternating samples give no step", trim_code, MID);
  endtask

  task automatic t_sat(input logic lead, input logic [19:0] rail);
    int s0;
    do_reset(lead, 1'b0);
    run_to(2);
    cfg_wr = 1'b1; cfg_wdata = rail;
    run_to(3);
    cfg_wr = 1'b0;
    check("R7 write loads word", trim_code, rail);
    s0 = sat_cnt;
    run_to(66);
    check("R6 word held at rail", trim_code, rail);
    check("R6 one saturation pulse", 20'(sat_cnt - s0), 20'h1);
  endtask

  task automatic t_manual;
    do_reset(1'b1, 1'b1);
    run_to(200);
    check("R8 manual blocks correction", trim_code, MID);
    cfg_wr = 1'b1; cfg_wdata = 20'h0F0F0;
    run_to(201);
    cfg_wr = 1'b0;
    check("R8 write accepted in manual", trim_code, 20'h0F0F0);
    cfg_rd = 1'b1;
    run_to(202);
    cfg_rd = 1'b0;
    check("R7 readback", cfg_rdata, 20'h0F0F0);
    cfg_manual = 1'b0;
    run_to(256);
    check("R8 fresh samples needed after manual", trim_code, 20'h0F0F0);
    run_to(257);
    check("R8 step after four fresh samples", trim_code, 20'h1E1E0);
  endtask

  task automatic t_priority;
    int s0;
    s0 = sat_cnt;
    do_reset(1'b1, 1'b0);
    run_to(64);
    cfg_wr = 1'b1; cfg_wdata = 20'hFFFF0;
    run_to(65);
    cfg_wr = 1'b0;
    check("R9 write beats correction", trim_code, 20'hFFFF0);
    run_to(128);
    check("R9 dropped correction not replayed", trim_code, 20'hFFFF0);
    run_to(129);
    check("R9 next step from fresh samples", trim_code, 20'hFFFE0);
    check("R9 no saturation", 20'(sat_cnt - s0), 20'h0);
  endtask

  initial begin
    t_reset;
    t_slow;
    t_fast;
    t_sync_delay;
    t_jitter;
    t_sat(1'b0, 20'hFFFFF);
    t_sat(1'b1, 20'h00000);
    t_manual;
    t_priority;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule